// File: doc/BRIEF.md
# I2C-over-AUX Transfer Segmenter

This block turns a short list of I2C messages into a sequence of AUX I2C transactions. Each message has a 7-bit device address, a direction and a length from 0 to 255 bytes. Before a transfer, the message bytes sit in a small internal byte buffer, packed one after the other from offset 0. A host loads the buffer through a byte port and loads the messages through a descriptor port. It then starts the transfer with a message count.

The segmenter walks the messages in order and cuts each one into chunks of up to 16 bytes. For each chunk it raises one AUX request carrying a command code, the device address and the chunk length. It waits for the engine's done/error reply before it moves on. While a chunk is open, the engine pulls write bytes by index from the buffer, or pushes read bytes by index into it.

The hold flag in the command keeps the I2C bus claimed on every chunk except the final chunk of the final message. The first failing chunk ends the whole transfer. A transfer that succeeds reports how many messages it processed.

Top module: `i2cx_segmenter`

## Requirements
- R1: A message with `r` bytes left is issued as a chunk of min(r, 16) bytes, shown on `aux_len` as the byte count itself (1..16).
- R2: Bit 0 of `aux_cmd` is 1 for a read message and 0 for a write message. Bits 1 and 3 are always 0.
- R3: Bit 2 of `aux_cmd` (hold, value 0x4) is set when more messages follow in the transfer, or when more than 16 bytes remain in the current message. It is clear only on the final chunk of the final message.
- R4: Every chunk carries its message's device address on `aux_addr`. Command, address and length stay stable from the request until the reply.
- R5: Messages occupy the buffer back to back from offset 0. The pointer advances by each chunk's size. During a write chunk, `aux_wdata` is the buffer byte at pointer + `aux_widx`.
- R6: During a read chunk, each `aux_rvalid` beat stores `aux_rdata` at buffer offset pointer + `aux_ridx`. The stored bytes can be read back through `host_rdata`.
- R7: A zero-length message produces no AUX request and takes no buffer space. Processing continues with the next message.
- R8: An error reply ends the transfer at once. `xfer_done` pulses with `xfer_ok` = 0 and `xfer_msgs` = index of the failing message, and no further request follows.
- R9: When every chunk succeeds, `xfer_done` pulses for one cycle with `xfer_ok` = 1 and `xfer_msgs` = the message count. A count of 0 completes with no request.
- R10: `aux_start` is a one-cycle pulse per chunk. No new request is raised while a reply is still outstanding.
- R11: While `busy` is high, host buffer writes, descriptor writes and `xfer_start` are ignored.
- R12: After reset, `busy`, `xfer_done` and `aux_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host buffer byte write strobe |
| host_addr | input | 8 | Host buffer byte address (write and read) |
| host_wdata | input | 8 | Host buffer write byte |
| host_rdata | output | 8 | Buffer byte at `host_addr` |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 2 | Descriptor slot |
| desc_dev | input | 7 | Device address of the message |
| desc_rd | input | 1 | 1 = read message, 0 = write |
| desc_len | input | 8 | Message length in bytes |
| xfer_start | input | 1 | Start a transfer |
| xfer_nmsg | input | 3 | Number of messages (clamped to 4) |
| busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_ok | output | 1 | Transfer result, valid with `xfer_done` |
| xfer_msgs | output | 3 | Messages processed or failing index |
| aux_start | output | 1 | Chunk request pulse |
| aux_cmd | output | 4 | Chunk command code |
| aux_addr | output | 7 | Chunk device address |
| aux_len | output | 5 | Chunk byte count |
| aux_widx | input | 4 | Write byte index pulled by the engine |
| aux_wdata | output | 8 | Write byte at that index |
| aux_rvalid | input | 1 | Read byte strobe from the engine |
| aux_ridx | input | 4 | Read byte index |
| aux_rdata | input | 8 | Read byte |
| aux_done | input | 1 | Chunk reply strobe |
| aux_err | input | 1 | Chunk failed, valid with `aux_done` |

## Verification
A wrong remaining count or message index appears on the next request as a wrong length, or as a misplaced hold bit or direction bit. A wrong buffer pointer appears one request later as wrong write bytes on `aux_wdata`, or as read bytes stored at offsets that the host readback exposes. Each request is compared with an independently computed chunk list as it happens. Errors in abort or completion show at the single `xfer_done` pulse, through its result fields and through any request issued after it.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int CHUNK_MAX = 16;
  localparam int CHUNK_W   = 5;
  localparam int LEN_W     = 8;

  localparam logic [3:0] CMD_WR  = 4'h0;
  localparam logic [3:0] CMD_RD  = 4'h1;
  localparam logic [3:0] CMD_MOT = 4'h4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_PICK, ST_ISSUE, ST_WAIT
  } seg_state_e;

  typedef struct packed {
    logic [6:0]       dev;
    logic             rd;
    logic [LEN_W-1:0] len;
  } desc_t;

  // Bytes carried by the next chunk.
  function automatic logic [CHUNK_W-1:0] chunk_of(input logic [LEN_W-1:0] rem);
    return (rem > LEN_W'(CHUNK_MAX)) ? CHUNK_W'(CHUNK_MAX) : rem[CHUNK_W-1:0];
  endfunction

  // Command code for the next chunk: direction plus bus hold.
  function automatic logic [3:0] cmd_of(input logic rd, input logic more_msgs,
                                        input logic [LEN_W-1:0] rem);
    logic [3:0] c;
    c = rd ? CMD_RD : CMD_WR;
    if (more_msgs || (rem > LEN_W'(CHUNK_MAX))) c = c | CMD_MOT;
    return c;
  endfunction
endpackage

// File: rtl/i2cx_byte_ram.sv
module i2cx_byte_ram #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/i2cx_desc_tab.sv
module i2cx_desc_tab import i2cx_pkg::*; #(
  parameter int SLOTS = 4,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  desc_t         wdesc,
  input  logic [IW-1:0] ridx,
  output desc_t         rdesc
);
  desc_t slot [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot[i] <= '0;
    end else if (we) begin
      slot[widx] <= wdesc;
    end
  end

  assign rdesc = slot[ridx];
endmodule

// File: rtl/i2cx_segmenter.sv
module i2cx_segmenter import i2cx_pkg::*; #(
  parameter int MSG_MAX   = 4,
  parameter int BUF_DEPTH = 256,
  localparam int AW    = $clog2(BUF_DEPTH),
  localparam int IDX_W = (MSG_MAX > 1) ? $clog2(MSG_MAX) : 1,
  localparam int MSG_W = $clog2(MSG_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [AW-1:0]      host_addr,
  input  logic [7:0]         host_wdata,
  output logic [7:0]         host_rdata,
  input  logic               desc_we,
  input  logic [IDX_W-1:0]   desc_idx,
  input  logic [6:0]         desc_dev,
  input  logic               desc_rd,
  input  logic [LEN_W-1:0]   desc_len,
  input  logic               xfer_start,
  input  logic [MSG_W-1:0]   xfer_nmsg,
  output logic               busy,
  output logic               xfer_done,
  output logic               xfer_ok,
  output logic [MSG_W-1:0]   xfer_msgs,
  output logic               aux_start,
  output logic [3:0]         aux_cmd,
  output logic [6:0]         aux_addr,
  output logic [CHUNK_W-1:0] aux_len,
  input  logic [3:0]         aux_widx,
  output logic [7:0]         aux_wdata,
  input  logic               aux_rvalid,
  input  logic [3:0]         aux_ridx,
  input  logic [7:0]         aux_rdata,
  input  logic               aux_done,
  input  logic               aux_err
);
  seg_state_e         state;
  logic [MSG_W-1:0]   n_r, msg_i;
  logic [LEN_W-1:0]   rem;
  logic [AW-1:0]      ptr;
  logic               done_r, ok_r;
  logic [MSG_W-1:0]   msgs_r;

  desc_t              cur;
  logic [CHUNK_W-1:0] chunk;
  logic               more_msgs, in_xact;
  logic               host_wr_ok, desc_wr_ok, start_ok;
  logic               chunk_reply, chunk_fail, rd_store, all_sent;
  logic               ram_we;
  logic [AW-1:0]      ram_waddr;
  logic [7:0]         ram_wdata;

  // named events
  assign busy        = (state != ST_IDLE);
  assign in_xact     = (state == ST_ISSUE) || (state == ST_WAIT);
  assign host_wr_ok  = host_we && !busy;
  assign desc_wr_ok  = desc_we && !busy;
  assign start_ok    = xfer_start && !busy;
  assign chunk_reply = (state == ST_WAIT) && aux_done;
  assign chunk_fail  = chunk_reply && aux_err;
  assign rd_store    = (state == ST_WAIT) && cur.rd && aux_rvalid;
  assign all_sent    = (msg_i == n_r);

  assign chunk     = chunk_of(rem);
  assign more_msgs = ({1'b0, msg_i} + 1'b1) < {1'b0, n_r};

  i2cx_desc_tab #(.SLOTS(MSG_MAX)) u_desc (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (desc_wr_ok),
    .widx  (desc_idx),
    .wdesc ('{dev: desc_dev, rd: desc_rd, len: desc_len}),
    .ridx  (msg_i[IDX_W-1:0]),
    .rdesc (cur)
  );

  assign ram_we    = rd_store || host_wr_ok;
  assign ram_waddr = rd_store ? (ptr + AW'(aux_ridx)) : host_addr;
  assign ram_wdata = rd_store ? aux_rdata : host_wdata;

  i2cx_byte_ram #(.DEPTH(BUF_DEPTH)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr_a (host_addr),
    .rdata_a (host_rdata),
    .raddr_b (ptr + AW'(aux_widx)),
    .rdata_b (aux_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      n_r    <= '0;
      msg_i  <= '0;
      rem    <= '0;
      ptr    <= '0;
      done_r <= 1'b0;
      ok_r   <= 1'b0;
      msgs_r <= '0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_ok) begin
          n_r   <= (xfer_nmsg > MSG_W'(MSG_MAX)) ? MSG_W'(MSG_MAX) : xfer_nmsg;
          msg_i <= '0;
          ptr   <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: if (all_sent) begin
          done_r <= 1'b1;
          ok_r   <= 1'b1;
          msgs_r <= n_r;
          state  <= ST_IDLE;
        end else begin
          rem   <= cur.len;
          state <= ST_PICK;
        end
        ST_PICK: if (rem == '0) begin
          msg_i <= msg_i + 1'b1;
          state <= ST_LOAD;
        end else begin
          state <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (chunk_fail) begin
          done_r <= 1'b1;
          ok_r   <= 1'b0;
          msgs_r <= msg_i;
          state  <= ST_IDLE;
        end else if (chunk_reply) begin
          ptr   <= ptr + AW'(chunk);
          rem   <= rem - LEN_W'(chunk);
          state <= ST_PICK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign aux_start = (state == ST_ISSUE);
  assign aux_cmd   = in_xact ? cmd_of(cur.rd, more_msgs, rem) : 4'h0;
  assign aux_addr  = in_xact ? cur.dev : 7'h0;
  assign aux_len   = in_xact ? chunk : '0;
  assign xfer_done = done_r;
  assign xfer_ok   = ok_r;
  assign xfer_msgs = msgs_r;
endmodule

// File: rtl/i2cx_segmenter_chk.sv
module i2cx_segmenter_chk import i2cx_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               aux_start,
  input logic [3:0]         aux_cmd,
  input logic [6:0]         aux_addr,
  input logic [CHUNK_W-1:0] aux_len,
  input logic               aux_done,
  input logic               aux_err,
  input logic               busy,
  input logic               xfer_done
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)         pending <= 1'b0;
    else if (aux_start) pending <= 1'b1;
    else if (aux_done)  pending <= 1'b0;
  end

  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    aux_start |-> (aux_len >= CHUNK_W'(1)) && (aux_len <= CHUNK_W'(CHUNK_MAX)));

  p_cmd_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    aux_start |-> ((aux_cmd & 4'hA) == 4'h0));

  p_fields_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !aux_done) |=> ($stable(aux_cmd) && $stable(aux_addr) && $stable(aux_len)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && aux_done && aux_err) |=> !busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);

  p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    aux_start |=> !aux_start);

  p_one_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
    aux_start |-> !pending);

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    aux_start |-> busy);
endmodule

bind i2cx_segmenter i2cx_segmenter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .aux_start (aux_start),
  .aux_cmd   (aux_cmd),
  .aux_addr  (aux_addr),
  .aux_len   (aux_len),
  .aux_done  (aux_done),
  .aux_err   (aux_err),
  .busy      (busy),
  .xfer_done (xfer_done)
);

// File: tb/i2cx_segmenter_tb_top.sv
`timescale 1ns/1ps
module i2cx_segmenter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
  logic       desc_we = 1'b0;
  logic [1:0] desc_idx = '0;
  logic [6:0] desc_dev = '0;
  logic       desc_rd = 1'b0;
  logic [7:0] desc_len = '0;
  logic       xfer_start = 1'b0;
  logic [2:0] xfer_nmsg = '0;
  logic       busy, xfer_done, xfer_ok;
  logic [2:0] xfer_msgs;
  logic       aux_start;
  logic [3:0] aux_cmd;
  logic [6:0] aux_addr;
  logic [4:0] aux_len;
  logic [3:0] aux_widx = '0;
  logic [7:0] aux_wdata;
  logic       aux_rvalid = 1'b0;
  logic [3:0] aux_ridx = '0;
  logic [7:0] aux_rdata = '0;
  logic       aux_done = 1'b0, aux_err = 1'b0;

  always #2.5 clk = ~clk;

  i2cx_segmenter dut_i (.*);

  int checks = 0, errors = 0, cycles = 0;
  int model_mem [256];
  int m_dev [4], m_rd [4], m_len [4];
  int q_cmd [$], q_addr [$], q_len [$], q_base [$];
  int issued = 0, eng_fail = -1, salt = 0;
  int exp_ok, exp_msgs, exp_issued;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // AUX engine model
  initial begin
    forever begin
      @(negedge clk);
      if (aux_start) begin
        int c, a, l, b;
        c = aux_cmd; a = aux_addr; l = aux_len;
        if (q_cmd.size() == 0) begin
          chk("R8/R10 unexpected request", 1, 0);
          b = 0;
        end else begin
          chk("R2 direction bit", c & 1, q_cmd[0] & 1);
          chk("R3 hold bit", c & 4, q_cmd[0] & 4);
          chk("R4 device address", a, q_addr[0]);
          chk("R1 chunk length", l, q_len[0]);
          b = q_base[0];
          void'(q_cmd.pop_front()); void'(q_addr.pop_front());
          void'(q_len.pop_front()); void'(q_base.pop_front());
        end
        @(negedge clk);
        if ((c & 1) == 0) begin
          for (int i = 0; i < l; i++) begin
            aux_widx = 4'(i);
            #0.1;
            chk("R5 write byte", aux_wdata, model_mem[(b + i) % 256]);
          end
        end else begin
          for (int i = 0; i < l; i++) begin
            aux_rvalid = 1'b1;
            aux_ridx = 4'(i);
            aux_rdata = 8'(((b + i) ^ 8'h5A ^ salt) & 8'hFF);
            model_mem[(b + i) % 256] = ((b + i) ^ 8'h5A ^ salt) & 8'hFF;
            @(negedge clk);
          end
          aux_rvalid = 1'b0;
        end
        aux_done = 1'b1;
        aux_err = (issued == eng_fail);
        issued++;
        @(negedge clk);
        aux_done = 1'b0;
        aux_err = 1'b0;
      end
    end
  end

  task automatic set_msg(input int k, input int dev, input int rd, input int len);
    m_dev[k] = dev; m_rd[k] = rd; m_len[k] = len;
    @(negedge clk);
    desc_we = 1'b1; desc_idx = 2'(k); desc_dev = 7'(dev); desc_rd = rd[0]; desc_len = 8'(len);
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic build_expect(input int n, input int fail_at);
    int base, cidx;
    bit stop;
    base = 0; cidx = 0; stop = 0;
    exp_ok = 1; exp_msgs = n;
    for (int k = 0; k < n && !stop; k++) begin
      int left;
      left = m_len[k];
      while (left > 0 && !stop) begin
        int sz;
        bit last;
        sz = (left < 16) ? left : 16;
        last = (k == n - 1) && (left <= 16);
        q_cmd.push_back(m_rd[k] + (last ? 0 : 4));
        q_addr.push_back(m_dev[k]);
        q_len.push_back(sz);
        q_base.push_back(base);
        if (cidx == fail_at) begin
          stop = 1; exp_ok = 0; exp_msgs = k;
        end
        cidx++; base += sz; left -= sz;
      end
    end
    exp_issued = cidx;
  endtask

  task automatic run_xfer(input int n, input int fail_at, input bit poke, input string tag);
    int guard;
    build_expect(n, fail_at);
    issued = 0; eng_fail = fail_at;
    @(negedge clk);
    xfer_nmsg = 3'(n); xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    if (poke) begin
      chk("R11 busy during transfer", busy, 1);
      host_we = 1'b1; host_addr = 8'd200; host_wdata = 8'hEE;
      desc_we = 1'b1; desc_idx = 2'd0; desc_dev = 7'h7F; desc_rd = 1'b1; desc_len = 8'd1;
      xfer_start = 1'b1;
      @(negedge clk);
      host_we = 1'b0; desc_we = 1'b0; xfer_start = 1'b0;
    end
    guard = 0;
    while (!xfer_done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk({tag, " done seen"}, xfer_done, 1);
    chk({tag, " ok flag"}, xfer_ok, exp_ok);
    chk({tag, " message count"}, xfer_msgs, exp_msgs);
    chk({tag, " requests issued"}, issued, exp_issued);
    repeat (6) @(negedge clk);
    chk({tag, " requests pending"}, q_cmd.size(), 0);
    chk({tag, " idle after"}, busy, 0);
  endtask

  task automatic host_check(input int a, input string tag);
    @(negedge clk);
    host_addr = 8'(a);
    #0.1;
    chk(tag, host_rdata, model_mem[a]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R12 busy after reset", busy, 0);
    chk("R12 done after reset", xfer_done, 0);
    chk("R12 request after reset", aux_start, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 256; i++) begin
      model_mem[i] = (i * 7 + 3) & 8'hFF;
      @(negedge clk);
      host_we = 1'b1; host_addr = 8'(i); host_wdata = 8'(model_mem[i]);
    end
    @(negedge clk);
    host_we = 1'b0;

    // single short write
    set_msg(0, 7'h50, 0, 5);
    run_xfer(1, -1, 0, "R9 single write");

    // long write split into 16/16/8, with writes poked while busy
    set_msg(0, 7'h3A, 0, 40);
    run_xfer(1, -1, 1, "R1 long write");
    host_check(200, "R11 host write ignored while busy");

    // write then read across chunks
    salt = 8'h11;
    set_msg(0, 7'h50, 0, 2);
    set_msg(1, 7'h51, 1, 20);
    run_xfer(2, -1, 0, "R6 write then read");
    for (int i = 2; i < 22; i++) host_check(i, "R6 read byte stored");

    // zero-length message in the middle
    salt = 8'h22;
    set_msg(0, 7'h10, 0, 3);
    set_msg(1, 7'h11, 0, 0);
    set_msg(2, 7'h12, 1, 1);
    run_xfer(3, -1, 0, "R7 zero length");
    host_check(3, "R7 zero length takes no space");

    // empty transfer
    run_xfer(0, -1, 0, "R9 empty");

    // four messages, last one long read
    salt = 8'h33;
    set_msg(0, 7'h01, 1, 17);
    set_msg(1, 7'h02, 0, 16);
    set_msg(2, 7'h03, 0, 1);
    set_msg(3, 7'h04, 1, 33);
    run_xfer(4, -1, 0, "R3 four messages");
    for (int i = 0; i < 67; i += 11) host_check(i, "R6 read byte stored");

    // error in the middle of a long message
    set_msg(0, 7'h3A, 0, 40);
    run_xfer(1, 1, 0, "R8 error mid message");

    // error on second message
    set_msg(0, 7'h20, 0, 2);
    set_msg(1, 7'h21, 0, 2);
    run_xfer(2, 1, 0, "R8 error second message");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule